// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block gathers every reason a small microcontroller core may need to restart and turns them into one orderly reset sequence. It watches an asynchronous external reset pin, a power-on indication from the supply monitor, a one-clock watchdog timeout pulse and a stop-mode flag from the core. From these it drives the core reset and three companion signals. A program-counter-clear pulse fires as reset begins. A port-preset level holds the I/O latches at all ones. A watchdog-interval strobe fires as reset ends, so the watchdog restarts at its shortest interval. Scratchpad and data memories are never touched, so no clear signal for them exists.

The external pin is resynchronised and must be seen high across two machine cycles before it counts, so short glitches are filtered out. The reset then lasts as long as the pin stays high, and the core is released within two machine cycles after the pin goes low. If the core is in stop mode, the oscillator is halted. In that case a high pin is taken at once. The block asks the oscillator to start and waits for it to acknowledge, then applies a long stabilisation delay before release. Power-on uses a fixed delay that ends on its own. Two sticky flags record power-on and watchdog causes, and the reported source falls back to the external pin when neither flag is set.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_n` is low, `core_rst` is high and both flags are clear. After `rst_n` rises, `core_rst` is first seen low after exactly POR_DLY_CLKS rising edges, and `wdt_intv_rst` is high in that cycle.
- R2: With stop mode off, a high external pin asserts `core_rst`. It is first seen high after at least 3+(DETECT_MC-1)*MC_CLKS and at most 2+DETECT_MC*MC_CLKS rising edges, counting the first edge that samples the pin as edge 1.
- R3: The pin never asserts `core_rst` if no run of consecutive high samples is longer than MC_CLKS clocks. This holds for any number of such runs, as long as each is separated by at least one low clock, because the detection count restarts on every low sample.
- R4: `core_rst` stays high for as long as the pin stays high. After the pin goes low, `core_rst` is first seen low after at least 4+(EXIT_MC-1)*MC_CLKS and at most 3+EXIT_MC*MC_CLKS rising edges.
- R5: With `stop_mode` high, a high pin asserts `core_rst` and `osc_start` after exactly 3 rising edges. `osc_start` stays high until `osc_ready` is sampled high.
- R6: In the stop-mode case, `core_rst` is first seen low exactly STAB_CLKS+1 rising edges after `osc_ready` goes high, provided the pin is low by then. If the pin is still high, reset continues and ends as in R4.
- R7: `por_in` high asserts `core_rst` after one edge and holds it. After `por_in` falls, `core_rst` is first seen low after exactly POR_DLY_CLKS edges, with no other input needed.
- R8: A `wdt_timeout` pulse while running asserts `core_rst` after one edge. `core_rst` is first seen low after at least 2+(EXIT_MC-1)*MC_CLKS and at most 1+EXIT_MC*MC_CLKS edges from the pulse.
- R9: `por_flag` is set by `por_in` and `wdt_flag` by `wdt_timeout`. Both stay set through later external resets and clear only on `flag_clr`. A set and a clear in the same cycle leave the flag set.
- R10: `rst_src` reads 2'b10 while `por_flag` is set. It reads 2'b01 when only `wdt_flag` is set, and 2'b00 (external pin) when neither flag is set.
- R11: `pc_clear` is high exactly in the first cycle of each reset. `wdt_intv_rst` is high exactly in the first cycle after each reset ends. `port_preset` is high throughout every reset.
- R12: If the pin rises again before the core is released, reset continues without a gap until the pin is released again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, always running for this block |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| ext_rst_pin | input | 1 | Asynchronous external reset pin, active high |
| por_in | input | 1 | Power-on indication from the supply monitor, active high |
| wdt_timeout | input | 1 | One-clock watchdog expiry pulse |
| stop_mode | input | 1 | Core is in stop mode with its oscillator halted |
| osc_ready | input | 1 | Oscillator acknowledges the start request |
| flag_clr | input | 1 | Software strobe clearing both cause flags |
| core_rst | output | 1 | Reset to the core, active high |
| pc_clear | output | 1 | One-cycle request to load the program counter with 0000h |
| port_preset | output | 1 | Holds the port latches at FFh during reset |
| wdt_intv_rst | output | 1 | One-cycle strobe returning the watchdog to its shortest interval |
| osc_start | output | 1 | Request to start the oscillator |
| por_flag | output | 1 | Sticky power-on cause flag |
| wdt_flag | output | 1 | Sticky watchdog cause flag |
| rst_src | output | 2 | Reset source: 00 external, 01 watchdog, 10 power-on |

## Verification
The hardest situation to reach from the ports is a pin pulse that ends at the last safe point. In that case the detection counter has seen exactly one machine-cycle tick, and a second tick a clock later would have taken the reset. The bench reaches it by sweeping pulse widths from one clock up to a full machine cycle at every tick phase, and by chaining full-length pulses with single-clock gaps. It also re-raises the pin inside the release window. Finally, it drives the stop-mode path with the pin still high when the stabilisation delay ends, so that the hand-over into the normal hold state is exercised.

// File: rtl/rstseq_pkg.sv
// Shared types for the reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rstseq_pkg;

    // Sequencer states; only SEQ_RUN lets the core execute.
    typedef enum logic [2:0] {
        SEQ_RUN  = 3'd0,
        SEQ_PWR  = 3'd1,
        SEQ_EXT  = 3'd2,
        SEQ_EXIT = 3'd3,
        SEQ_OSCW = 3'd4,
        SEQ_STAB = 3'd5
    } seq_state_t;

    // Reported reset source codes.
    localparam logic [1:0] SRC_EXT = 2'b00;
    localparam logic [1:0] SRC_WDT = 2'b01;
    localparam logic [1:0] SRC_POR = 2'b10;

endpackage

// File: rtl/rstseq_sync.sv
// Multi-stage synchroniser for the asynchronous external reset pin.
// Assumes: STAGES >= 2; the output lags the input by STAGES edges.
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] shreg;

    // Shift the pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-2:0], d_async};
        end
    end

    assign q_sync = shreg[STAGES-1];

endmodule

// File: rtl/rstseq_mctick.sv
// Machine-cycle tick generator: one high clock every MC_CLKS clocks.
// Assumes: free-running from the block reset; phase is not aligned to any input.
module rstseq_mctick #(
    parameter int MC_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (MC_CLKS == 1) begin : g_every
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(MC_CLKS);
            logic [CW-1:0] phase;

            // Count clocks within one machine cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    phase <= '0;
                end else if (phase == CW'(MC_CLKS - 1)) begin
                    phase <= '0;
                end else begin
                    phase <= phase + CW'(1);
                end
            end

            assign tick = (phase == CW'(MC_CLKS - 1));
        end
    endgenerate

endmodule

// File: rtl/rstseq_pindet.sv
// Qualifies the synchronised pin: fires once DETECT_MC ticks were seen while high.
// Assumes: any low sample restarts the count; the count saturates while high.
module rstseq_pindet #(
    parameter int DETECT_MC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic tick,
    output logic fire
);

    localparam int DW = (DETECT_MC < 2) ? 1 : $clog2(DETECT_MC);

    logic [DW-1:0] seen;

    // Count machine-cycle ticks during an unbroken high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (!pin_s) begin
            seen <= '0;
        end else if (tick && (seen != DW'(DETECT_MC - 1))) begin
            seen <= seen + DW'(1);
        end
    end

    assign fire = pin_s && tick && (seen == DW'(DETECT_MC - 1));

endmodule

// File: rtl/rstseq_flags.sv
// Sticky cause flags and the derived source code.
// Assumes: a set and a clear in the same cycle leave the flag set.
module rstseq_flags
    import rstseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_in,
    input  logic       wdt_timeout,
    input  logic       flag_clr,
    output logic       por_flag,
    output logic       wdt_flag,
    output logic [1:0] rst_src
);

    // Power-on flag: set by the monitor, cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_flag <= 1'b0;
        end else if (por_in) begin
            por_flag <= 1'b1;
        end else if (flag_clr) begin
            por_flag <= 1'b0;
        end
    end

    // Watchdog flag: set by a timeout pulse, cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_flag <= 1'b0;
        end else if (wdt_timeout) begin
            wdt_flag <= 1'b1;
        end else if (flag_clr) begin
            wdt_flag <= 1'b0;
        end
    end

    // Source priority: power-on, then watchdog, else the external pin.
    always_comb begin
        if (por_flag) begin
            rst_src = SRC_POR;
        end else if (wdt_flag) begin
            rst_src = SRC_WDT;
        end else begin
            rst_src = SRC_EXT;
        end
    end

endmodule

// File: rtl/rstseq_top.sv
// Reset sequencer top: qualifies reset causes and walks the core through
// entry, hold, oscillator start, stabilisation and release.
// Assumes: clk runs even when the core is in stop mode; por_in and
// wdt_timeout are synchronous to clk; osc_ready is a level acknowledge.
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int MC_CLKS      = 4,
    parameter int DETECT_MC    = 2,
    parameter int EXIT_MC      = 2,
    parameter int STAB_CLKS    = 65536,
    parameter int POR_DLY_CLKS = 65536,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_rst_pin,
    input  logic       por_in,
    input  logic       wdt_timeout,
    input  logic       stop_mode,
    input  logic       osc_ready,
    input  logic       flag_clr,
    output logic       core_rst,
    output logic       pc_clear,
    output logic       port_preset,
    output logic       wdt_intv_rst,
    output logic       osc_start,
    output logic       por_flag,
    output logic       wdt_flag,
    output logic [1:0] rst_src
);

    localparam int DLY_MAX = (STAB_CLKS > POR_DLY_CLKS) ? STAB_CLKS : POR_DLY_CLKS;
    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam int EX_W    = (EXIT_MC < 2) ? 1 : $clog2(EXIT_MC);

    logic             pin_s;
    logic             tick;
    logic             det_fire;
    seq_state_t       state;
    logic [DLY_W-1:0] dly_cnt;
    logic [EX_W-1:0]  ex_cnt;
    logic             rst_q;

    rstseq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(ext_rst_pin),
        .q_sync (pin_s)
    );

    rstseq_mctick #(.MC_CLKS(MC_CLKS)) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    rstseq_pindet #(.DETECT_MC(DETECT_MC)) det_i (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_s(pin_s),
        .tick (tick),
        .fire (det_fire)
    );

    rstseq_flags flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_in     (por_in),
        .wdt_timeout(wdt_timeout),
        .flag_clr   (flag_clr),
        .por_flag   (por_flag),
        .wdt_flag   (wdt_flag),
        .rst_src    (rst_src)
    );

    // Sequencer state with its delay and exit counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_PWR;
            dly_cnt <= '0;
            ex_cnt  <= '0;
        end else if (por_in) begin
            state   <= SEQ_PWR;
            dly_cnt <= '0;
        end else begin
            case (state)
                SEQ_RUN: begin
                    if (stop_mode && pin_s) begin
                        state <= SEQ_OSCW;
                    end else if (det_fire) begin
                        state <= SEQ_EXT;
                    end else if (wdt_timeout) begin
                        state  <= SEQ_EXIT;
                        ex_cnt <= '0;
                    end
                end
                SEQ_EXT: begin
                    if (!pin_s) begin
                        state  <= SEQ_EXIT;
                        ex_cnt <= '0;
                    end
                end
                SEQ_EXIT: begin
                    if (pin_s) begin
                        state <= SEQ_EXT;
                    end else if (tick) begin
                        if (ex_cnt == EX_W'(EXIT_MC - 1)) begin
                            state <= SEQ_RUN;
                        end else begin
                            ex_cnt <= ex_cnt + EX_W'(1);
                        end
                    end
                end
                SEQ_OSCW: begin
                    if (osc_ready) begin
                        state   <= SEQ_STAB;
                        dly_cnt <= '0;
                    end
                end
                SEQ_STAB: begin
                    if (dly_cnt == DLY_W'(STAB_CLKS - 1)) begin
                        state <= pin_s ? SEQ_EXT : SEQ_RUN;
                    end else begin
                        dly_cnt <= dly_cnt + DLY_W'(1);
                    end
                end
                SEQ_PWR: begin
                    if (dly_cnt == DLY_W'(POR_DLY_CLKS - 1)) begin
                        state <= SEQ_RUN;
                    end else begin
                        dly_cnt <= dly_cnt + DLY_W'(1);
                    end
                end
                default: state <= SEQ_PWR;
            endcase
        end
    end

    // Previous-cycle reset level, for the entry and exit strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b1;
        end else begin
            rst_q <= core_rst;
        end
    end

    assign core_rst     = (state != SEQ_RUN);
    assign osc_start    = (state == SEQ_OSCW);
    assign port_preset  = core_rst;
    assign pc_clear     = core_rst && !rst_q;
    assign wdt_intv_rst = !core_rst && rst_q;

endmodule

// File: rtl/rstseq_chk.sv
// Property checker for the reset sequencer, bound to rstseq_top.
// Assumes: all properties are disabled while rst_n is low.
module rstseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_in,
    input logic       wdt_timeout,
    input logic       flag_clr,
    input logic       osc_ready,
    input logic       core_rst,
    input logic       pc_clear,
    input logic       wdt_intv_rst,
    input logic       osc_start,
    input logic       por_flag,
    input logic       wdt_flag,
    input logic [1:0] rst_src
);

    p_osc_in_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        osc_start |-> core_rst);

    p_osc_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_start) |-> $past(osc_ready || por_in));

    p_por_enters_r7: assert property (@(posedge clk) disable iff (!rst_n)
        por_in |=> (core_rst && por_flag));

    p_wdt_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> wdt_flag);

    p_por_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_flag) |-> $past(flag_clr));

    p_wdt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_flag) |-> $past(flag_clr));

    p_src_por_r10: assert property (@(posedge clk) disable iff (!rst_n)
        por_flag |-> (rst_src == 2'b10));

    p_entry_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> pc_clear);

    p_exit_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> wdt_intv_rst);

endmodule

bind rstseq_top rstseq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_in      (por_in),
    .wdt_timeout (wdt_timeout),
    .flag_clr    (flag_clr),
    .osc_ready   (osc_ready),
    .core_rst    (core_rst),
    .pc_clear    (pc_clear),
    .wdt_intv_rst(wdt_intv_rst),
    .osc_start   (osc_start),
    .por_flag    (por_flag),
    .wdt_flag    (wdt_flag),
    .rst_src     (rst_src)
);

// File: tb/rstseq_top_tb_top.sv
// Self-checking bench for rstseq_top on a shortened delay configuration.
module rstseq_top_tb_top;

    localparam int C    = 4;
    localparam int D    = 2;
    localparam int E    = 2;
    localparam int STAB = 24;
    localparam int POR  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst_pin = 1'b0;
    logic       por_in = 1'b0;
    logic       wdt_timeout = 1'b0;
    logic       stop_mode = 1'b0;
    logic       osc_ready = 1'b0;
    logic       flag_clr = 1'b0;
    logic       core_rst;
    logic       pc_clear;
    logic       port_preset;
    logic       wdt_intv_rst;
    logic       osc_start;
    logic       por_flag;
    logic       wdt_flag;
    logic [1:0] rst_src;

    int  errs = 0;
    int  checks = 0;
    bit  seen_hi;
    bit  seen_lo;
    int  n;

    always #2 clk = ~clk;

    rstseq_top #(
        .MC_CLKS(C), .DETECT_MC(D), .EXIT_MC(E),
        .STAB_CLKS(STAB), .POR_DLY_CLKS(POR), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_rst_pin(ext_rst_pin), .por_in(por_in),
        .wdt_timeout(wdt_timeout), .stop_mode(stop_mode), .osc_ready(osc_ready),
        .flag_clr(flag_clr), .core_rst(core_rst), .pc_clear(pc_clear),
        .port_preset(port_preset), .wdt_intv_rst(wdt_intv_rst),
        .osc_start(osc_start), .por_flag(por_flag), .wdt_flag(wdt_flag),
        .rst_src(rst_src)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (core_rst) seen_hi = 1'b1;
        else          seen_lo = 1'b1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what,
                           input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // Step until core_rst reaches lvl; returns the number of edges taken.
    task automatic wait_lvl(input logic lvl, output int cnt);
        cnt = 0;
        do begin
            step();
            cnt++;
        end while (core_rst != lvl && cnt < 2000);
    endtask

    // Full external reset cycle with range checks on both edges.
    task automatic ext_cycle(input int hold);
        int m;
        ext_rst_pin = 1'b1;
        wait_lvl(1'b1, m);
        chk_rng("R2", "assert latency", m, 3 + (D - 1) * C, 2 + D * C);
        chk(pc_clear && port_preset, "R11", "entry strobe/preset", int'(pc_clear), 1);
        seen_lo = 1'b0;
        repeat (hold) step();
        chk(!seen_lo, "R4", "held while pin high", int'(seen_lo), 0);
        ext_rst_pin = 1'b0;
        wait_lvl(1'b0, m);
        chk_rng("R4", "release latency", m, 4 + (E - 1) * C, 3 + E * C);
        chk(wdt_intv_rst, "R11", "exit strobe", int'(wdt_intv_rst), 1);
        step();
        chk(!wdt_intv_rst && !pc_clear, "R11", "strobes one cycle", int'(wdt_intv_rst), 0);
    endtask

    initial begin
        #(4 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // R1: reset state and power-on delay after block reset.
        repeat (3) @(negedge clk);
        chk(core_rst && !por_flag && !wdt_flag, "R1", "reset state core_rst", int'(core_rst), 1);
        chk(port_preset, "R11", "preset during reset", int'(port_preset), 1);
        rst_n = 1'b1;
        wait_lvl(1'b0, n);
        chk(n == POR, "R1", "power-on release edges", n, POR);
        chk(wdt_intv_rst, "R1", "exit strobe after reset", int'(wdt_intv_rst), 1);
        chk(rst_src == 2'b00, "R10", "source external by default", int'(rst_src), 0);
        repeat (3) step();

        // R2/R4/R11: external reset at every tick phase.
        for (int ph = 0; ph < C; ph++) begin
            repeat (ph + 5) step();
            ext_cycle(3 * C + ph);
        end
        chk(!por_flag && !wdt_flag, "R9", "external reset sets no flag", int'(por_flag), 0);

        // R3: short pulses of every width up to one machine cycle, all phases.
        for (int ph = 0; ph < C; ph++) begin
            for (int w = 1; w <= C; w++) begin
                repeat (ph) step();
                seen_hi = 1'b0;
                ext_rst_pin = 1'b1;
                repeat (w) step();
                ext_rst_pin = 1'b0;
                repeat (3 * C) step();
                chk(!seen_hi, "R3", "short pulse ignored", int'(seen_hi), 0);
            end
        end
        // R3: chained full-cycle pulses separated by one low clock.
        seen_hi = 1'b0;
        for (int k = 0; k < 8; k++) begin
            ext_rst_pin = 1'b1;
            repeat (C) step();
            ext_rst_pin = 1'b0;
            step();
        end
        repeat (3 * C) step();
        chk(!seen_hi, "R3", "pulse train with 1-clock gaps ignored", int'(seen_hi), 0);

        // R12: pin re-raised inside the release window.
        ext_rst_pin = 1'b1;
        wait_lvl(1'b1, n);
        repeat (2) step();
        ext_rst_pin = 1'b0;
        seen_lo = 1'b0;
        repeat (3) step();
        ext_rst_pin = 1'b1;
        repeat (4 * C) step();
        chk(!seen_lo, "R12", "no gap on re-assert", int'(seen_lo), 0);
        ext_rst_pin = 1'b0;
        wait_lvl(1'b0, n);
        chk_rng("R12", "release after re-assert", n, 4 + (E - 1) * C, 3 + E * C);
        repeat (4) step();

        // R8/R9/R10: watchdog reset.
        wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
        chk(core_rst && pc_clear, "R8", "watchdog enters reset", int'(core_rst), 1);
        chk(wdt_flag, "R9", "watchdog flag set", int'(wdt_flag), 1);
        wait_lvl(1'b0, n);
        chk_rng("R8", "watchdog release edges", n + 1, 2 + (E - 1) * C, 1 + E * C);
        chk(rst_src == 2'b01, "R10", "source watchdog", int'(rst_src), 1);
        repeat (3) step();
        ext_cycle(C);
        chk(wdt_flag, "R9", "watchdog flag survives external reset", int'(wdt_flag), 1);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(!wdt_flag && rst_src == 2'b00, "R9", "watchdog flag cleared", int'(wdt_flag), 0);

        // R7/R9/R10: power-on during run.
        por_in = 1'b1;
        step();
        chk(core_rst && por_flag, "R7", "power-on enters reset", int'(core_rst), 1);
        repeat (5) step();
        por_in = 1'b0;
        wait_lvl(1'b0, n);
        chk(n == POR, "R7", "power-on release edges", n, POR);
        chk(rst_src == 2'b10, "R10", "source power-on", int'(rst_src), 2);
        repeat (3) step();
        wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
        chk(rst_src == 2'b10, "R10", "power-on outranks watchdog", int'(rst_src), 2);
        wait_lvl(1'b0, n);
        repeat (3) step();
        ext_cycle(C);
        chk(por_flag && wdt_flag, "R9", "both flags survive external reset", int'(por_flag), 1);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(!por_flag && !wdt_flag, "R9", "clear strobe clears both", int'(por_flag), 0);
        // R9: set and clear together keeps the flag.
        flag_clr = 1'b1;
        wdt_timeout = 1'b1;
        step();
        flag_clr = 1'b0;
        wdt_timeout = 1'b0;
        chk(wdt_flag, "R9", "set wins over clear", int'(wdt_flag), 1);
        wait_lvl(1'b0, n);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        repeat (3) step();

        // R5/R6: stop-mode reset, pin released before stabilisation ends.
        stop_mode = 1'b1;
        ext_rst_pin = 1'b1;
        wait_lvl(1'b1, n);
        chk(n == 3, "R5", "stop-mode entry edges", n, 3);
        chk(osc_start && pc_clear, "R5", "oscillator request and pc clear", int'(osc_start), 1);
        repeat (10) step();
        chk(osc_start && core_rst, "R5", "request held until ready", int'(osc_start), 1);
        ext_rst_pin = 1'b0;
        osc_ready = 1'b1;
        step();
        chk(!osc_start && core_rst, "R5", "request dropped on ready", int'(osc_start), 0);
        wait_lvl(1'b0, n);
        chk(n + 1 == STAB + 1, "R6", "stabilisation release edges", n + 1, STAB + 1);
        osc_ready = 1'b0;
        repeat (4) step();

        // R6: stop-mode reset with the pin still high after stabilisation.
        ext_rst_pin = 1'b1;
        wait_lvl(1'b1, n);
        osc_ready = 1'b1;
        seen_lo = 1'b0;
        repeat (STAB + 4) step();
        chk(!seen_lo && !osc_start, "R6", "held past delay while pin high", int'(seen_lo), 0);
        stop_mode = 1'b0;
        osc_ready = 1'b0;
        ext_rst_pin = 1'b0;
        wait_lvl(1'b0, n);
        chk_rng("R6", "normal release after delay", n, 4 + (E - 1) * C, 3 + E * C);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule